// File: doc/BRIEF.md
# Serial Dual-Latch LED Control Interface

This block is the digital front end of a 16-channel constant-current LED driver. A host shifts words in serially on a data line, one bit per serial-clock rising edge. The most significant bit of the 16-bit shift register is driven on a serial output, so several drivers can be chained. A strobe input commits the register to one of two 16-bit latches.

The strobe does not carry an address. The level of the serial clock at the strobe's rising edge selects the destination. With the clock low, the word becomes the per-channel enable mask. With the clock high, the word becomes the control word. The control word is split into a power-save flag, two 2-bit current-measurement timing and current fields, a 2-bit short-detect threshold, a 2-bit status-source selector and a 7-bit brightness value.

When a control write selects a status source, that source's 16 fault flags are loaded into the shift register in parallel. They can then be read back on the serial output. The fault flags come from analog comparators outside the block, which are treated as quasi-static digital inputs. The serial pins are asynchronous to the system clock and are synchronised inside the block.

Top module: `led_dual_latch_if`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows chan_en = 0, every control field = 0 and ser_out = 0.
- R2: Each ser_clk rising edge shifts the register one place toward bit 15 and takes ser_in into bit 0. After 16 edges, the register holds the 16 most recent ser_in bits, with the first bit sent in bit 15.
- R3: ser_out changes only after a ser_clk falling edge, and then shows the register's bit 15.
- R4: A lat rising edge while ser_clk is low copies the register into chan_en, where bit n enables channel n. The control fields are left unchanged.
- R5: A lat rising edge while ser_clk is high copies the register into the control word and leaves chan_en unchanged. The fields are pwr_save = bit 15, idm_time = bits 14:13, idm_cur = bits 12:11, lsd_vsel = bits 10:9, stat_mode = bits 8:7 and bright = bits 6:0.
- R6: On that control-word write, bits 8:7 of the word being written choose what is loaded into the register: 00 keeps the register, 01 loads open_flags, 10 loads short_flags and 11 loads leak_flags. Flag bit n is register bit n, where 1 means a fault. The loaded word is then shifted out on ser_out, most significant bit first.
- R7: A latch changes only on a rising edge of lat. Holding lat high while new data is shifted in, and the falling edge of lat, leave both latches unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_in | input | 1 | Serial data in |
| lat | input | 1 | Latch strobe (asynchronous) |
| open_flags | input | 16 | Per-channel open-LED fault flags |
| short_flags | input | 16 | Per-channel shorted-LED fault flags |
| leak_flags | input | 16 | Per-channel output-leakage fault flags |
| ser_out | output | 1 | Serial data out for chaining |
| chan_en | output | 16 | Per-channel output enable |
| pwr_save | output | 1 | Power-save enable |
| idm_time | output | 2 | Current-measurement working-time select |
| idm_cur | output | 2 | Current-measurement current select |
| lsd_vsel | output | 2 | Short-detect threshold select |
| stat_mode | output | 2 | Status-source selector |
| bright | output | 7 | Global brightness code |

## Verification
The hardest case to reach from the ports is a control write. It needs ser_clk to be raised first, and that rise itself shifts one more bit in. The status load must then replace the register in the same step, and the result only becomes visible after the following ser_clk fall. The bench therefore sends the first 15 bits of each control word as ordinary pulses, and sends the last bit with the clock rise that precedes the strobe. It then shifts the register out and compares it with the flag word that the selector names. It runs this for all four selector codes, and also for random words sent to random destinations. A directed sequence holds lat high while new data is shifted in, to show that only the strobe's rising edge commits a latch.

// File: rtl/led_dual_latch_pkg.sv
// Package: shared widths and types of the LED dual-latch interface.
// Assumes a 16-channel driver; the control word layout is fixed at 16 bits.
package led_dual_latch_pkg;
    localparam int N_CH = 16;

    // Control word, most significant field first (bit 15 down to bit 0).
    typedef struct packed {
        logic       pwr_save;   // 15
        logic [1:0] idm_time;   // 14:13
        logic [1:0] idm_cur;    // 12:11
        logic [1:0] lsd_vsel;   // 10:9
        logic [1:0] stat_mode;  // 8:7
        logic [6:0] bright;     // 6:0
    } ctrl_word_t;

    typedef enum logic [1:0] {
        SL_NONE  = 2'b00,
        SL_OPEN  = 2'b01,
        SL_SHORT = 2'b10,
        SL_LEAK  = 2'b11
    } stat_sel_e;
endpackage

// File: rtl/ldl_in_sync.sv
// Module: multi-bit level synchroniser with per-bit edge detection.
// Assumes each input bit is an independent slow asynchronous level; the
// edge outputs are single-cycle pulses aligned with the synchronised level.
module ldl_in_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prev;

    // Shift the raw inputs through the synchroniser chain and keep the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
            prev <= '0;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            prev <= chain[STAGES-1];
        end
    end

    // Derive the synchronised level and its edges.
    always_comb begin
        lvl  = chain[STAGES-1];
        rise = chain[STAGES-1] & ~prev;
        fall = ~chain[STAGES-1] & prev;
    end
endmodule

// File: rtl/ldl_shift_core.sv
// Module: 16-bit common shift register with status parallel load and
// falling-edge serial output. Assumes the flag inputs are quasi-static and
// that a control-word write never coincides with a serial-clock fall.
module ldl_shift_core
    import led_dual_latch_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sin,
    input  logic            shift_en,
    input  logic            out_upd,
    input  logic            stat_load,
    input  logic [N_CH-1:0] open_flags,
    input  logic [N_CH-1:0] short_flags,
    input  logic [N_CH-1:0] leak_flags,
    output logic [N_CH-1:0] shreg,
    output logic            ser_out
);
    stat_sel_e       sel;
    logic [N_CH-1:0] stat_word;
    logic            do_load;

    // Pick the status source named by the control word being written.
    always_comb begin
        sel = stat_sel_e'(shreg[8:7]);
        unique case (sel)
            SL_OPEN:  stat_word = open_flags;
            SL_SHORT: stat_word = short_flags;
            SL_LEAK:  stat_word = leak_flags;
            default:  stat_word = shreg;
        endcase
        do_load = stat_load && (sel != SL_NONE);
    end

    // Register update: a status load wins over a shift.
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (do_load)  shreg <= stat_word;
        else if (shift_en) shreg <= {shreg[N_CH-2:0], sin};
    end

    // Present the MSB downstream only after a serial-clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n)       ser_out <= 1'b0;
        else if (out_upd) ser_out <= shreg[N_CH-1];
    end

    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en && !stat_load |=> shreg == {$past(shreg[N_CH-2:0]), $past(sin)}); // R2
    AST_SOUT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_upd |=> ser_out == $past(shreg[N_CH-1])); // R3
    AST_SOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_upd |=> $stable(ser_out)); // R3
    AST_STAT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        stat_load && shreg[8:7] == 2'b10 |=> shreg == $past(short_flags)); // R6
    AST_STAT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        stat_load && shreg[8:7] == 2'b00 && !shift_en |=> $stable(shreg)); // R6
endmodule

// File: rtl/ldl_latch_bank.sv
// Module: the two destination latches, enable mask and control word.
// Assumes lat_rise is a single-cycle pulse and sel_ctrl is valid with it.
module ldl_latch_bank
    import led_dual_latch_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] shreg,
    input  logic            lat_rise,
    input  logic            sel_ctrl,
    output logic [N_CH-1:0] chan_en,
    output ctrl_word_t      ctrl
);
    // Commit the shift register to the enable mask on a low-clock strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                    chan_en <= '0;
        else if (lat_rise && !sel_ctrl) chan_en <= shreg;
    end

    // Commit the shift register to the control word on a high-clock strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ctrl <= '0;
        else if (lat_rise && sel_ctrl) ctrl <= ctrl_word_t'(shreg);
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> chan_en == '0 && ctrl == '0); // R1
    AST_ONOFF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        lat_rise && !sel_ctrl |=> chan_en == $past(shreg) && $stable(ctrl)); // R4
    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        lat_rise && sel_ctrl |=> ctrl == $past(shreg) && $stable(chan_en)); // R5
    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_rise |=> $stable(chan_en) && $stable(ctrl)); // R7
endmodule

// File: rtl/led_dual_latch_if.sv
// Module: top of the serial dual-latch LED control interface.
// Synchronises the serial pins, then routes edges to the shift core and the
// latch bank; the serial clock level at the strobe edge selects the latch.
module led_dual_latch_if
    import led_dual_latch_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ser_clk,
    input  logic            ser_in,
    input  logic            lat,
    input  logic [N_CH-1:0] open_flags,
    input  logic [N_CH-1:0] short_flags,
    input  logic [N_CH-1:0] leak_flags,
    output logic            ser_out,
    output logic [N_CH-1:0] chan_en,
    output logic            pwr_save,
    output logic [1:0]      idm_time,
    output logic [1:0]      idm_cur,
    output logic [1:0]      lsd_vsel,
    output logic [1:0]      stat_mode,
    output logic [6:0]      bright
);
    localparam int IDX_SIN = 0;
    localparam int IDX_SCK = 1;
    localparam int IDX_LAT = 2;
    localparam int N_SYNC  = 3;

    logic [N_SYNC-1:0] s_lvl, s_rise, s_fall;
    logic [N_CH-1:0]   shreg;
    logic              strobe, to_ctrl;
    ctrl_word_t        ctrl;

    ldl_in_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({lat, ser_clk, ser_in}),
        .lvl  (s_lvl),
        .rise (s_rise),
        .fall (s_fall)
    );

    // Strobe edge and the serial clock level sampled in the same cycle.
    always_comb begin
        strobe  = s_rise[IDX_LAT];
        to_ctrl = s_lvl[IDX_SCK];
    end

    ldl_shift_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .sin        (s_lvl[IDX_SIN]),
        .shift_en   (s_rise[IDX_SCK]),
        .out_upd    (s_fall[IDX_SCK]),
        .stat_load  (strobe && to_ctrl),
        .open_flags (open_flags),
        .short_flags(short_flags),
        .leak_flags (leak_flags),
        .shreg      (shreg),
        .ser_out    (ser_out)
    );

    ldl_latch_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .shreg   (shreg),
        .lat_rise(strobe),
        .sel_ctrl(to_ctrl),
        .chan_en (chan_en),
        .ctrl    (ctrl)
    );

    // Break the control word out onto its field ports.
    always_comb begin
        pwr_save  = ctrl.pwr_save;
        idm_time  = ctrl.idm_time;
        idm_cur   = ctrl.idm_cur;
        lsd_vsel  = ctrl.lsd_vsel;
        stat_mode = ctrl.stat_mode;
        bright    = ctrl.bright;
    end
endmodule

// File: tb/led_dual_latch_if_test.sv
module led_dual_latch_if_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_in = 1'b0, lat = 1'b0;
    logic [15:0] open_flags = 16'h0000, short_flags = 16'h0000, leak_flags = 16'h0000;
    logic        ser_out;
    logic [15:0] chan_en;
    logic        pwr_save;
    logic [1:0]  idm_time, idm_cur, lsd_vsel, stat_mode;
    logic [6:0]  bright;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_sh = 16'h0, m_on = 16'h0, m_ctrl = 16'h0;
    logic        m_out = 1'b0;

    always #5 clk = ~clk;

    led_dual_latch_if uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_in(ser_in), .lat(lat),
        .open_flags(open_flags), .short_flags(short_flags), .leak_flags(leak_flags),
        .ser_out(ser_out), .chan_en(chan_en), .pwr_save(pwr_save), .idm_time(idm_time),
        .idm_cur(idm_cur), .lsd_vsel(lsd_vsel), .stat_mode(stat_mode), .bright(bright)
    );

    function automatic logic [15:0] ctrl_out();
        return {pwr_save, idm_time, idm_cur, lsd_vsel, stat_mode, bright};
    endfunction

    function automatic logic [15:0] status_for(logic [15:0] w, logic [15:0] keep);
        case (w[8:7])
            2'b01:   return open_flags;
            2'b10:   return short_flags;
            2'b11:   return leak_flags;
            default: return keep;
        endcase
    endfunction

    task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(logic b);
        ser_in = b;
        wait_n(6);
        ser_clk = 1'b1;
        m_sh = {m_sh[14:0], b};
        wait_n(6);
        ser_clk = 1'b0;
        m_out = m_sh[15];
        wait_n(6);
        chk(ser_out === m_out, "R3", {15'h0, ser_out}, {15'h0, m_out});
    endtask

    task automatic write_word(logic [15:0] w);
        for (int i = 15; i >= 0; i--) pulse(w[i]);
    endtask

    task automatic latch_on();
        lat = 1'b1;
        wait_n(6);
        m_on = m_sh;
        lat = 1'b0;
        wait_n(6);
        chk(chan_en === m_on, "R4/R2 enable mask", chan_en, m_on);
        chk(ctrl_out() === m_ctrl, "R4 control kept", ctrl_out(), m_ctrl);
    endtask

    task automatic load_ctrl(logic [15:0] w);
        for (int i = 15; i >= 1; i--) pulse(w[i]);
        ser_in = w[0];
        wait_n(6);
        ser_clk = 1'b1;
        m_sh = {m_sh[14:0], w[0]};
        wait_n(6);
        lat = 1'b1;
        wait_n(6);
        m_ctrl = m_sh;
        m_sh = status_for(m_sh, m_sh);
        lat = 1'b0;
        wait_n(6);
        ser_clk = 1'b0;
        m_out = m_sh[15];
        wait_n(6);
        chk(ctrl_out() === m_ctrl, "R5 control word", ctrl_out(), m_ctrl);
        chk(chan_en === m_on, "R5 enable kept", chan_en, m_on);
        chk(ser_out === m_out, "R3", {15'h0, ser_out}, {15'h0, m_out});
    endtask

    task automatic read_back(logic [15:0] exp, string tag);
        logic [15:0] got;
        got[15] = ser_out;
        for (int i = 14; i >= 0; i--) begin
            pulse(1'b0);
            got[i] = ser_out;
        end
        chk(got === exp, tag, got, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] w, a;
        void'($urandom(32'd20240607));
        open_flags  = 16'h8421;
        short_flags = 16'h1E0F;
        leak_flags  = 16'hF0A5;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);
        // R1: reset state
        chk(chan_en === 16'h0, "R1 enable", chan_en, 16'h0);
        chk(ctrl_out() === 16'h0, "R1 control", ctrl_out(), 16'h0);
        chk({15'h0, ser_out} === 16'h0, "R1 ser_out", {15'h0, ser_out}, 16'h0);

        // R2/R4: directed enable-mask writes
        write_word(16'hA5C3);
        latch_on();
        write_word(16'hFFFF);
        latch_on();
        write_word(16'h0001);
        latch_on();

        // R5/R6: each status selector code, read back on ser_out
        load_ctrl(16'b1_01_10_11_01_1010101);
        read_back(open_flags, "R6 open flags");
        load_ctrl(16'b0_10_01_00_10_0000001);
        read_back(short_flags, "R6 short flags");
        load_ctrl(16'b1_11_11_11_11_1111111);
        read_back(leak_flags, "R6 leak flags");
        w = 16'b0_00_11_01_00_1110000;
        load_ctrl(w);
        read_back(w, "R6 no load keeps word");

        // R7: lat held high while shifting, then its falling edge
        a = 16'h3C69;
        write_word(a);
        lat = 1'b1;
        wait_n(6);
        m_on = m_sh;
        write_word(16'hC396);
        chk(chan_en === a, "R7 lat held high", chan_en, a);
        lat = 1'b0;
        wait_n(8);
        chk(chan_en === a, "R7 lat falling edge", chan_en, a);
        chk(ctrl_out() === m_ctrl, "R7 control kept", ctrl_out(), m_ctrl);

        // Random words to random destinations
        for (int it = 0; it < 24; it++) begin
            w = 16'($urandom);
            if ($urandom % 2 == 1) begin
                load_ctrl(w);
                if (it % 3 == 0) read_back(status_for(w, w), "R6 random readback");
            end else begin
                write_word(w);
                latch_on();
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule